// File: doc/BRIEF.md
# Fracturable three-input lookup table

This block is one configurable logic element of a programmable fabric. A single eight-entry truth table either serves as one lookup table with three inputs, or divides into two independent four-entry tables with two inputs each. Both halves read the same low input bits. One configuration bit picks the arrangement. Because that bit is part of the programmed word, the arrangement stays fixed while the fabric runs.

The element is purely combinational and has no clock or reset. The configuration arrives as one flat parallel word. Loading that word and registering the outputs are handled elsewhere.

Both outputs stay at 0 until the programming-done flag is raised. They also stay at 0 while the element's enable bit is cleared. This way, a partly loaded or unused element never drives stray values into the routing.

Top module: `flut3_frac`

## Requirements
- R1: In full mode (cfg[9] = 0), with prog_done = 1 and cfg[8] = 1, dout0 equals cfg[din]. Table entry i sits at cfg bit i, for i from 0 to 7.
- R2: In split mode (cfg[9] = 1), with prog_done = 1 and cfg[8] = 1, dout0 equals cfg[din[1:0]]. This reads table bits 0 to 3.
- R3: In split mode, with prog_done = 1 and cfg[8] = 1, dout1 equals cfg[4 + din[1:0]]. This reads table bits 4 to 7.
- R4: In split mode, din[2] has no effect on either output.
- R5: While prog_done = 0, both outputs are 0 for every din and cfg.
- R6: While the enable bit cfg[8] = 0, both outputs are 0 for every din, table content and mode.
- R7: In full mode, dout1 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| din | input | 3 | Lookup inputs; bit 2 is used only in full mode |
| cfg | input | 10 | Bits 7:0 truth table, bit 8 enable, bit 9 mode (1 = split) |
| prog_done | input | 1 | High once the fabric configuration is complete |
| dout0 | output | 1 | Three-input result in full mode; lower-half result in split mode |
| dout1 | output | 1 | Upper-half result in split mode; 0 in full mode |

## Verification
The bench builds the element with its default three-input width, so the whole input space can be covered exhaustively. That space is eight lookup indices, both modes, both enable values and both done values. This sweep is repeated over a set of truth tables that includes all-zero, all-one, alternating and walking-one patterns. A stuck or swapped table entry in either half therefore shows up at the ports. Each split-mode vector with din[2] set is compared against the expectation computed from din[1:0] alone, which shows that the top input bit is ignored.

// File: rtl/flut_pkg.sv
package flut_pkg;

  // Arrangement selected by the mode bit of the configuration word.
  typedef enum logic {
    MODE_FULL  = 1'b0,
    MODE_SPLIT = 1'b1
  } flut_mode_e;

endpackage

// File: rtl/flut_mux.sv
// Picks one entry of a small truth table by a binary index.
module flut_mux #(
  parameter int SEL_W = 2,
  localparam int DEPTH = 1 << SEL_W
) (
  input  logic [DEPTH-1:0] table_bits,
  input  logic [SEL_W-1:0] sel,
  output logic             bit_out
);

  function automatic logic pick(input logic [DEPTH-1:0] t, input logic [SEL_W-1:0] s);
    logic r;
    r = 1'b0;
    for (int k = 0; k < DEPTH; k++) begin
      if (s == SEL_W'(k)) r = t[k];
    end
    return r;
  endfunction

  assign bit_out = pick(table_bits, sel);

endmodule

// File: rtl/flut_gate.sv
// Routes the half results by mode and forces both outputs low unless live.
module flut_gate
  import flut_pkg::*;
(
  input  flut_mode_e mode,
  input  logic       live,
  input  logic       full_bit,
  input  logic       lo_bit,
  input  logic       hi_bit,
  output logic       out0,
  output logic       out1
);

  always_comb begin
    out0 = 1'b0;
    out1 = 1'b0;
    if (live) begin
      if (mode == MODE_SPLIT) begin
        out0 = lo_bit;
        out1 = hi_bit;
      end else begin
        out0 = full_bit;
      end
    end
  end

endmodule

// File: rtl/flut3_frac.sv
module flut3_frac
  import flut_pkg::*;
#(
  parameter int IN_W = 3,
  localparam int ENTRIES  = 1 << IN_W,
  localparam int HALF     = ENTRIES / 2,
  localparam int EN_POS   = ENTRIES,
  localparam int MODE_POS = ENTRIES + 1,
  localparam int CFG_W    = ENTRIES + 2
) (
  input  logic [IN_W-1:0]  din,
  input  logic [CFG_W-1:0] cfg,
  input  logic             prog_done,
  output logic             dout0,
  output logic             dout1
);

  // Named internal events, visible to the bound checker.
  logic       live;
  flut_mode_e split_mode;
  logic       lo_bit;
  logic       hi_bit;
  logic       full_bit;
  logic [1:0] half_bits;

  assign live       = prog_done & cfg[EN_POS];
  assign split_mode = flut_mode_e'(cfg[MODE_POS]);

  // Two half tables share the low input bits.
  for (genvar h = 0; h < 2; h++) begin : g_half
    flut_mux #(.SEL_W(IN_W - 1)) u_mux (
      .table_bits (cfg[h*HALF +: HALF]),
      .sel        (din[IN_W-2:0]),
      .bit_out    (half_bits[h])
    );
  end

  assign lo_bit = half_bits[0];
  assign hi_bit = half_bits[1];

  // The full result reuses both halves, steered by the top input bit.
  assign full_bit = din[IN_W-1] ? hi_bit : lo_bit;

  flut_gate u_gate (
    .mode     (split_mode),
    .live     (live),
    .full_bit (full_bit),
    .lo_bit   (lo_bit),
    .hi_bit   (hi_bit),
    .out0     (dout0),
    .out1     (dout1)
  );

endmodule

// File: rtl/flut3_frac_chk.sv
module flut3_frac_chk #(
  parameter int IN_W = 3,
  localparam int ENTRIES = 1 << IN_W,
  localparam int CFG_W   = ENTRIES + 2
) (
  input logic [IN_W-1:0]  din,
  input logic [CFG_W-1:0] cfg,
  input logic             prog_done,
  input logic             dout0,
  input logic             dout1,
  input logic             live,
  input logic             is_split,
  input logic             lo_bit,
  input logic             hi_bit,
  input logic             full_bit
);

  always_comb begin
    if (!prog_done) begin
      assert_dead_low_R5: assert (dout0 == 1'b0 && dout1 == 1'b0)
        else $error("outputs active before programming done");
    end
    if (!cfg[ENTRIES]) begin
      assert_disabled_low_R6: assert (dout0 == 1'b0 && dout1 == 1'b0)
        else $error("outputs active while disabled");
    end
    if (live && !is_split) begin
      assert_full_pick_R1: assert (dout0 == full_bit)
        else $error("full-mode output mismatch");
      assert_full_hi_zero_R7: assert (dout1 == 1'b0)
        else $error("second output active in full mode");
    end
    if (live && is_split) begin
      assert_split_lo_R2: assert (dout0 == lo_bit)
        else $error("lower half mismatch");
      assert_split_hi_R3: assert (dout1 == hi_bit)
        else $error("upper half mismatch");
    end
  end

endmodule

bind flut3_frac flut3_frac_chk #(.IN_W(IN_W)) u_chk (
  .din       (din),
  .cfg       (cfg),
  .prog_done (prog_done),
  .dout0     (dout0),
  .dout1     (dout1),
  .live      (live),
  .is_split  (split_mode),
  .lo_bit    (lo_bit),
  .hi_bit    (hi_bit),
  .full_bit  (full_bit)
);

// File: tb/tb_flut3_frac.sv
`timescale 1ns/1ps
module tb_flut3_frac;

  logic       clk = 1'b0;
  logic [2:0] din = '0;
  logic [9:0] cfg = '0;
  logic       prog_done = 1'b0;
  logic       dout0;
  logic       dout1;

  int vectors = 0;
  int fails = 0;
  bit done_run = 1'b0;

  always #5 clk = ~clk;

  flut3_frac dut (
    .din       (din),
    .cfg       (cfg),
    .prog_done (prog_done),
    .dout0     (dout0),
    .dout1     (dout1)
  );

  task automatic check(input string req, input logic got, input logic exp);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: din=%0d cfg=%b done=%0b got=%0b expected=%0b",
               req, din, cfg, prog_done, got, exp);
    end
  endtask

  // Behavioural reference: integer shifts on the table value.
  task automatic apply(input int tbl, input int split, input int en, input int dn, input int idx);
    int e0, e1;
    string r0, r1;
    @(posedge clk);
    cfg       = 10'((split << 9) | (en << 8) | (tbl & 255));
    prog_done = dn[0];
    din       = 3'(idx);
    @(negedge clk);
    if (dn == 0) begin
      e0 = 0; e1 = 0; r0 = "R5"; r1 = "R5";
    end else if (en == 0) begin
      e0 = 0; e1 = 0; r0 = "R6"; r1 = "R6";
    end else if (split == 0) begin
      e0 = (tbl >> idx) & 1; e1 = 0; r0 = "R1"; r1 = "R7";
    end else begin
      e0 = (tbl >> (idx % 4)) & 1;
      e1 = (tbl >> (4 + idx % 4)) & 1;
      r0 = (idx >= 4) ? "R2/R4" : "R2";
      r1 = (idx >= 4) ? "R3/R4" : "R3";
    end
    check(r0, dout0, e0[0]);
    check(r1, dout1, e1[0]);
  endtask

  initial begin
    int tables[$];
    tables = '{8'h00, 8'hFF, 8'h96, 8'hE8, 8'h5A, 8'hA5, 8'h0F, 8'hF0};
    for (int b = 0; b < 8; b++) tables.push_back(1 << b);
    // Reset state: nothing programmed yet (R5).
    #2;
    check("R5", dout0, 1'b0);
    check("R5", dout1, 1'b0);
    foreach (tables[t]) begin
      for (int s = 0; s < 2; s++)
        for (int e = 0; e < 2; e++)
          for (int d = 0; d < 2; d++)
            for (int i = 0; i < 8; i++)
              apply(tables[t], s, e, d, i);
    end
    done_run = 1'b1;
  end

  initial begin
    fork
      begin wait (done_run); end
      begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got=timeout expected=completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule